// File: doc/BRIEF.md
# Reload and Dual Capture Timer

A 16-bit timer/counter that serves three purposes. As an auto-reload timer it counts prescaled system-clock ticks, or falling edges on the count pin, and refills itself from a 16-bit reload register whenever it wraps past FFFFh. As a baud-rate generator it produces a one-cycle overflow pulse for a serial port. It also drives a square wave on the count pin at half the overflow rate. As a capture unit it snapshots the running count on valid edges of the trigger pin into the reload register. A second, independent channel snapshots the count on edges of the count pin into its own register.

Software programs the block through an 8-bit register port with eight addresses. Both pins pass through two-flop synchronisers before any edge is detected. Valid edges can be falling-only, any level change, or rising-only. A main flag and an external flag are held until software clears them, and they feed an interrupt controller outside this block.

Top module: `reload_capture_timer`

## Requirements
- R1: Register map (3-bit address): 0 control, 1 mode, 2/3 count low/high, 4/5 reload-capture low/high, 6/7 capture-1 low/high (read-only, writes ignored). Control bits: 0 run, 1 count-pin clocking, 2 capture mode, 3 trigger enable, 4 receive-clock select, 5 transmit-clock select, 6 external flag, 7 main flag. Mode bits: 0 fast clock, 1 global fast, 2 clock output, 3 capture-1 enable, 5:4 edge select, 7:6 read as 0.
- R2: After reset every register reads 0, the count pin is not driven, and the flags and overflow pulse are low.
- R3: With run set and internal clocking, the count advances once every 12 clocks in standard mode, every 4 in fast mode, and every clock with fast and global fast both set. The first step comes that many clocks after the write that sets run.
- R4: Outside capture and baud modes, an increment from FFFFh loads the reload value, pulses the overflow output for that cycle and sets the main flag. The flag stays set until software writes it to 0.
- R5: With receive- or transmit-clock select set (baud mode), the tick period is 4 clocks, or 2 in fast mode (1 with global fast). The select bits appear on their outputs, overflow reloads the count, and the main flag is not set.
- R6: In reload mode with trigger enable set, a falling edge on the trigger pin reloads the count and sets the external flag. With trigger enable clear the edge changes neither.
- R7: In capture mode a valid trigger-pin edge copies the count into the reload-capture register and sets the external flag without changing the count. An overflow wraps the count to 0000h and sets the main flag.
- R8: Edge select 00 or 10 means falling edges, 01 means any level change and 11 means rising edges. It applies to both capture channels.
- R9: With capture-1 enable set in capture mode, internal clocking and no clock output, a valid count-pin edge copies the count into the capture-1 register and sets the main flag (bit 7). Overflow then leaves that flag alone.
- R10: With clock output set, the count pin is driven and its output toggles on every overflow.
- R11: With count-pin clocking and run set, the count advances once per falling edge of the count pin, independent of the prescaler.
- R12: A pin edge takes effect on the third rising clock edge after the pin changes. A capture that coincides with an increment stores the pre-increment count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigPin | input | 1 | External trigger / capture-2 pin |
| cntPinIn | input | 1 | Count pin input (count clock or capture-1 source) |
| cntPinOut | output | 1 | Divided clock driven onto the count pin |
| cntPinOe | output | 1 | Output enable for the count pin |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr |
| irqMain | output | 1 | Main flag: overflow, or capture-1 when that channel is on |
| irqExt | output | 1 | External trigger flag |
| baudPulse | output | 1 | One-cycle pulse on each overflow |
| rxUseThis | output | 1 | Receive clock taken from this timer |
| txUseThis | output | 1 | Transmit clock taken from this timer |

## Verification
The assertions check every cycle that the count steps by one or holds as its strobes dictate. They also check that a wrap reloads or clears the count according to mode, and that both capture registers receive the count as it stood before the capture edge. Further cycle checks cover the main flag (set by overflow, and kept clear in baud mode) and the clock-out toggle. Only the directed scenarios can show the prescaler periods, the three-edge synchroniser latency, the edge-select decoding on real pin waveforms, and that a disabled trigger leaves count and flag untouched.

// File: rtl/rct_pkg.sv
package rct_pkg;
  localparam int REG_W = 8;
  localparam int CNT_W = 2 * REG_W;

  localparam logic [2:0] ADDR_CTRL = 3'd0;
  localparam logic [2:0] ADDR_MODE = 3'd1;
  localparam logic [2:0] ADDR_CNTL = 3'd2;
  localparam logic [2:0] ADDR_CNTH = 3'd3;
  localparam logic [2:0] ADDR_RLDL = 3'd4;
  localparam logic [2:0] ADDR_RLDH = 3'd5;
  localparam logic [2:0] ADDR_CP1L = 3'd6;
  localparam logic [2:0] ADDR_CP1H = 3'd7;

  // control register bit positions
  localparam int C_RUN   = 0;
  localparam int C_EXTCK = 1;
  localparam int C_CAP   = 2;
  localparam int C_TRGEN = 3;
  localparam int C_RXSEL = 4;
  localparam int C_TXSEL = 5;
  localparam int C_EXTF  = 6;
  localparam int C_MAINF = 7;

  // mode register bit positions
  localparam int M_FAST  = 0;
  localparam int M_GFAST = 1;
  localparam int M_CKOUT = 2;
  localparam int M_CP1EN = 3;
  localparam int M_EDGE0 = 4;
  localparam int M_EDGE1 = 5;

  typedef struct packed {
    logic             incr;
    logic             trigReload;
    logic             capture2;
    logic             capture1;
    logic             rollToZero;
    logic             clkOutEn;
    logic             wrCntLo;
    logic             wrCntHi;
    logic             wrRldLo;
    logic             wrRldHi;
    logic [REG_W-1:0] wrData;
  } tmrStrobes_t;
endpackage

// File: rtl/rct_pin_sync.sv
module rct_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] shr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shr <= '1;
    else       shr <= {shr[STAGES-1:0], pin};
  end

  assign rise = shr[STAGES-1] & ~shr[STAGES];
  assign fall = ~shr[STAGES-1] & shr[STAGES];
endmodule

// File: rtl/rct_control.sv
module rct_control
  import rct_pkg::*;
#(
  parameter int STD_DIV       = 12,
  parameter int FAST_DIV      = 4,
  parameter int BAUD_STD_DIV  = 4,
  parameter int BAUD_FAST_DIV = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigPin,
  input  logic             cntPinIn,
  input  logic             regWrEn,
  input  logic [2:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             ovfEvent,
  output logic [REG_W-1:0] ctrlReg,
  output logic [REG_W-1:0] modeReg,
  output tmrStrobes_t      strobes
);
  localparam int MAXD = (STD_DIV > BAUD_STD_DIV) ? STD_DIV : BAUD_STD_DIV;
  localparam int PW   = (MAXD > 1) ? $clog2(MAXD) : 1;

  logic trigRise, trigFall, cntRise, cntFall;
  logic baudMode, capMode, cap1On, trigValid, cntValid;
  logic intTick, mainSet, extSet;
  logic [PW-1:0] presc, divM1;

  rct_pin_sync #(.STAGES(SYNC_STAGES)) u_trigSync (
    .clk(clk), .rstN(rstN), .pin(trigPin), .rise(trigRise), .fall(trigFall));
  rct_pin_sync #(.STAGES(SYNC_STAGES)) u_cntSync (
    .clk(clk), .rstN(rstN), .pin(cntPinIn), .rise(cntRise), .fall(cntFall));

  function automatic logic edgeOk(input logic r, input logic f, input logic [1:0] sel);
    if (!sel[0])     return f;
    else if (!sel[1]) return r | f;
    else             return r;
  endfunction

  assign baudMode  = ctrlReg[C_RXSEL] | ctrlReg[C_TXSEL];
  assign capMode   = ctrlReg[C_CAP] & ~baudMode;
  assign cap1On    = modeReg[M_CP1EN] & capMode & ~ctrlReg[C_EXTCK] & ~modeReg[M_CKOUT];
  assign trigValid = edgeOk(trigRise, trigFall, modeReg[M_EDGE1:M_EDGE0]);
  assign cntValid  = edgeOk(cntRise, cntFall, modeReg[M_EDGE1:M_EDGE0]);

  always_comb begin
    if (baudMode)
      divM1 = modeReg[M_FAST] ? (modeReg[M_GFAST] ? PW'(0) : PW'(BAUD_FAST_DIV - 1))
                              : PW'(BAUD_STD_DIV - 1);
    else
      divM1 = modeReg[M_FAST] ? (modeReg[M_GFAST] ? PW'(0) : PW'(FAST_DIV - 1))
                              : PW'(STD_DIV - 1);
  end

  assign intTick = ctrlReg[C_RUN] & ~ctrlReg[C_EXTCK] & (presc >= divM1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                 presc <= '0;
    else if (!ctrlReg[C_RUN] || ctrlReg[C_EXTCK] || intTick) presc <= '0;
    else                                       presc <= presc + PW'(1);
  end

  always_comb begin
    strobes            = '0;
    strobes.incr       = intTick | (ctrlReg[C_RUN] & ctrlReg[C_EXTCK] & cntFall);
    strobes.trigReload = ~capMode & ctrlReg[C_TRGEN] & trigFall;
    strobes.capture2   = capMode & trigValid;
    strobes.capture1   = cap1On & cntValid;
    strobes.rollToZero = capMode;
    strobes.clkOutEn   = modeReg[M_CKOUT];
    strobes.wrCntLo    = regWrEn && regAddr == ADDR_CNTL;
    strobes.wrCntHi    = regWrEn && regAddr == ADDR_CNTH;
    strobes.wrRldLo    = regWrEn && regAddr == ADDR_RLDL;
    strobes.wrRldHi    = regWrEn && regAddr == ADDR_RLDH;
    strobes.wrData     = regWrData;
  end

  assign mainSet = cap1On ? strobes.capture1 : (ovfEvent & ~baudMode);
  assign extSet  = strobes.trigReload | strobes.capture2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      modeReg <= '0;
    end else begin
      if (regWrEn && regAddr == ADDR_CTRL) ctrlReg <= regWrData;
      if (regWrEn && regAddr == ADDR_MODE) modeReg <= {2'b00, regWrData[5:0]};
      if (mainSet) ctrlReg[C_MAINF] <= 1'b1;
      if (extSet)  ctrlReg[C_EXTF]  <= 1'b1;
    end
  end
endmodule

// File: rtl/rct_datapath.sv
module rct_datapath
  import rct_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobes_t      strobes,
  output logic [CNT_W-1:0] countVal,
  output logic [CNT_W-1:0] reloadVal,
  output logic [CNT_W-1:0] cap1Val,
  output logic             ovfEvent,
  output logic             clkOut
);
  assign ovfEvent = strobes.incr && (countVal == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countVal <= '0;
    end else if (strobes.wrCntLo) begin
      countVal[REG_W-1:0] <= strobes.wrData;
    end else if (strobes.wrCntHi) begin
      countVal[CNT_W-1:REG_W] <= strobes.wrData;
    end else if (ovfEvent) begin
      countVal <= strobes.rollToZero ? '0 : reloadVal;
    end else if (strobes.trigReload) begin
      countVal <= reloadVal;
    end else if (strobes.incr) begin
      countVal <= countVal + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reloadVal <= '0;
    end else if (strobes.capture2) begin
      reloadVal <= countVal;
    end else if (strobes.wrRldLo) begin
      reloadVal[REG_W-1:0] <= strobes.wrData;
    end else if (strobes.wrRldHi) begin
      reloadVal[CNT_W-1:REG_W] <= strobes.wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cap1Val <= '0;
    else if (strobes.capture1) cap1Val <= countVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                clkOut <= 1'b0;
    else if (strobes.clkOutEn && ovfEvent)    clkOut <= ~clkOut;
  end
endmodule

// File: rtl/reload_capture_timer.sv
module reload_capture_timer
  import rct_pkg::*;
#(
  parameter int STD_DIV       = 12,
  parameter int FAST_DIV      = 4,
  parameter int BAUD_STD_DIV  = 4,
  parameter int BAUD_FAST_DIV = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigPin,
  input  logic       cntPinIn,
  output logic       cntPinOut,
  output logic       cntPinOe,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irqMain,
  output logic       irqExt,
  output logic       baudPulse,
  output logic       rxUseThis,
  output logic       txUseThis
);
  tmrStrobes_t      strobes;
  logic [REG_W-1:0] ctrlReg, modeReg;
  logic [CNT_W-1:0] countVal, reloadVal, cap1Val;
  logic             ovfEvent;

  rct_control #(
    .STD_DIV(STD_DIV), .FAST_DIV(FAST_DIV), .BAUD_STD_DIV(BAUD_STD_DIV),
    .BAUD_FAST_DIV(BAUD_FAST_DIV), .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .cntPinIn(cntPinIn),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .ovfEvent(ovfEvent), .ctrlReg(ctrlReg), .modeReg(modeReg), .strobes(strobes)
  );

  rct_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .countVal(countVal),
    .reloadVal(reloadVal), .cap1Val(cap1Val), .ovfEvent(ovfEvent), .clkOut(cntPinOut)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = ctrlReg;
      ADDR_MODE: regRdData = modeReg;
      ADDR_CNTL: regRdData = countVal[REG_W-1:0];
      ADDR_CNTH: regRdData = countVal[CNT_W-1:REG_W];
      ADDR_RLDL: regRdData = reloadVal[REG_W-1:0];
      ADDR_RLDH: regRdData = reloadVal[CNT_W-1:REG_W];
      ADDR_CP1L: regRdData = cap1Val[REG_W-1:0];
      default:   regRdData = cap1Val[CNT_W-1:REG_W];
    endcase
  end

  assign cntPinOe  = modeReg[M_CKOUT];
  assign irqMain   = ctrlReg[C_MAINF];
  assign irqExt    = ctrlReg[C_EXTF];
  assign baudPulse = ovfEvent;
  assign rxUseThis = ctrlReg[C_RXSEL];
  assign txUseThis = ctrlReg[C_TXSEL];
endmodule

// File: rtl/reload_capture_timer_checker.sv
module reload_capture_timer_checker
  import rct_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input tmrStrobes_t      strobes,
  input logic [CNT_W-1:0] countVal,
  input logic [CNT_W-1:0] reloadVal,
  input logic [CNT_W-1:0] cap1Val,
  input logic             ovfEvent,
  input logic             irqMain,
  input logic [REG_W-1:0] ctrlReg,
  input logic [REG_W-1:0] modeReg,
  input logic             cntPinOut,
  input logic             cntPinOe,
  input logic             regWrEn,
  input logic [2:0]       regAddr
);
  logic cntWrite, ctrlWrite;
  assign cntWrite  = strobes.wrCntLo | strobes.wrCntHi;
  assign ctrlWrite = regWrEn && regAddr == ADDR_CTRL;

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incr && !ovfEvent && !strobes.trigReload && !cntWrite)
    |=> countVal == $past(countVal) + CNT_W'(1)); // R3

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.incr && !strobes.trigReload && !cntWrite) |=> $stable(countVal)); // R3

  AST_RELOAD_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvent && !strobes.rollToZero && !cntWrite) |=> countVal == $past(reloadVal)); // R4

  AST_FLAG_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvent && !ctrlReg[C_RXSEL] && !ctrlReg[C_TXSEL] && !modeReg[M_CP1EN])
    |=> irqMain); // R4

  AST_BAUD_NO_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvent && (ctrlReg[C_RXSEL] || ctrlReg[C_TXSEL]) && !irqMain && !ctrlWrite)
    |=> !irqMain); // R5

  AST_CAPTURE_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvent && strobes.rollToZero && !cntWrite) |=> countVal == '0); // R7

  AST_CAP2_PRE_INCR: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture2 |=> reloadVal == $past(countVal)); // R12

  AST_CAP1_COPY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture1 |=> (cap1Val == $past(countVal)) && irqMain); // R9

  AST_CLKOUT_TOGGLE: assert property (@(posedge clk) disable iff (!rstN)
    (ovfEvent && cntPinOe) |=> cntPinOut != $past(cntPinOut)); // R10

  AST_CLKOUT_STEADY: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfEvent || !cntPinOe) |=> $stable(cntPinOut)); // R10
endmodule

bind reload_capture_timer reload_capture_timer_checker u_chk (
  .clk(clk), .rstN(rstN), .strobes(strobes), .countVal(countVal),
  .reloadVal(reloadVal), .cap1Val(cap1Val), .ovfEvent(ovfEvent),
  .irqMain(irqMain), .ctrlReg(ctrlReg), .modeReg(modeReg),
  .cntPinOut(cntPinOut), .cntPinOe(cntPinOe), .regWrEn(regWrEn), .regAddr(regAddr)
);

// File: tb/reload_capture_timer_test.sv
module reload_capture_timer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       trigPin = 1'b1;
  logic       cntPinIn = 1'b1;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic       cntPinOut, cntPinOe, irqMain, irqExt, baudPulse, rxUseThis, txUseThis;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  reload_capture_timer uut (
    .clk(clk), .rstN(rstN), .trigPin(trigPin), .cntPinIn(cntPinIn),
    .cntPinOut(cntPinOut), .cntPinOe(cntPinOe), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqMain(irqMain), .irqExt(irqExt), .baudPulse(baudPulse),
    .rxUseThis(rxUseThis), .txUseThis(txUseThis)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd8(input logic [2:0] a, output logic [7:0] v);
    regAddr = a;
    #1 v = regRdData;
  endtask

  task automatic rd16(input logic [2:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    rd8(lo, l);
    rd8(lo + 3'd1, h);
    v = {h, l};
  endtask

  task automatic setCount(input logic [15:0] v);
    wrReg(3'd2, v[7:0]);
    wrReg(3'd3, v[15:8]);
  endtask

  task automatic setReload(input logic [15:0] v);
    wrReg(3'd4, v[7:0]);
    wrReg(3'd5, v[15:8]);
  endtask

  task automatic idle();
    wrReg(3'd0, 8'h00);
    wrReg(3'd1, 8'h00);
  endtask

  task automatic tReset();
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd8(a[2:0], v);
      check($sformatf("R2 reset reg %0d", a), {8'h0, v}, 16'h0);
    end
    check("R2 reset pin oe", {15'h0, cntPinOe}, 16'h0);
    check("R2 reset flags", {13'h0, irqMain, irqExt, baudPulse}, 16'h0);
    wrReg(3'd1, 8'hFF);
    rd8(3'd1, v);
    check("R1 mode upper bits read zero", {8'h0, v}, 16'h003F);
    wrReg(3'd6, 8'h5A);
    rd8(3'd6, v);
    check("R1 capture-1 read-only", {8'h0, v}, 16'h0);
    idle();
  endtask

  task automatic tRates();
    logic [15:0] c;
    idle(); setCount(16'h0000);
    wrReg(3'd0, 8'h01);
    stepN(11); rd16(3'd2, c); check("R3 standard 11 clocks", c, 16'h0000);
    stepN(1);  rd16(3'd2, c); check("R3 standard 12 clocks", c, 16'h0001);
    wrReg(3'd0, 8'h00); setCount(16'h0000); wrReg(3'd1, 8'h01);
    wrReg(3'd0, 8'h01);
    stepN(20); rd16(3'd2, c); check("R3 fast 20 clocks", c, 16'h0005);
    wrReg(3'd0, 8'h00); setCount(16'h0000); wrReg(3'd1, 8'h03);
    wrReg(3'd0, 8'h01);
    stepN(7); rd16(3'd2, c); check("R3 global fast 7 clocks", c, 16'h0007);
    idle();
  endtask

  task automatic tReloadOvf();
    logic [15:0] c; logic [7:0] v;
    idle(); setReload(16'h1234); setCount(16'hFFFE); wrReg(3'd1, 8'h03);
    wrReg(3'd0, 8'h01);
    stepN(1);
    check("R4 overflow pulse", {15'h0, baudPulse}, 16'h1);
    stepN(1); rd16(3'd2, c);
    check("R4 reload after wrap", c, 16'h1234);
    check("R4 main flag set", {15'h0, irqMain}, 16'h1);
    stepN(5);
    check("R4 flag sticky", {15'h0, irqMain}, 16'h1);
    wrReg(3'd0, 8'h01); rd8(3'd0, v);
    check("R4 flag cleared by write", {8'h0, v}, 16'h0001);
    idle();
  endtask

  task automatic tBaud();
    logic [15:0] c;
    idle(); setReload(16'hABCD); setCount(16'hFFFE);
    wrReg(3'd0, 8'h11);
    check("R5 rx select out", {14'h0, rxUseThis, txUseThis}, 16'h2);
    stepN(7); rd16(3'd2, c); check("R5 baud std before wrap", c, 16'hFFFF);
    stepN(1); rd16(3'd2, c); check("R5 baud std reload", c, 16'hABCD);
    check("R5 no main flag", {15'h0, irqMain}, 16'h0);
    wrReg(3'd0, 8'h20); setCount(16'hFFFE); wrReg(3'd1, 8'h01);
    wrReg(3'd0, 8'h21);
    check("R5 tx select out", {14'h0, rxUseThis, txUseThis}, 16'h1);
    stepN(4); rd16(3'd2, c); check("R5 baud fast reload", c, 16'hABCD);
    check("R5 no main flag fast", {15'h0, irqMain}, 16'h0);
    idle();
  endtask

  task automatic tExtReload();
    logic [15:0] c;
    idle(); setReload(16'h5555); setCount(16'h0042);
    wrReg(3'd0, 8'h08);
    trigPin = 1'b0;
    stepN(2); rd16(3'd2, c); check("R12 no effect before third edge", c, 16'h0042);
    stepN(1); rd16(3'd2, c); check("R6 trigger reload", c, 16'h5555);
    check("R6 external flag", {15'h0, irqExt}, 16'h1);
    trigPin = 1'b1; stepN(4);
    wrReg(3'd0, 8'h00); setCount(16'h0042);
    trigPin = 1'b0; stepN(5);
    rd16(3'd2, c); check("R6 disabled trigger ignored count", c, 16'h0042);
    check("R6 disabled trigger ignored flag", {15'h0, irqExt}, 16'h0);
    trigPin = 1'b1; stepN(4);
    idle();
  endtask

  task automatic tCapture2();
    logic [15:0] c;
    idle(); setCount(16'h0777); wrReg(3'd0, 8'h04);
    trigPin = 1'b0; stepN(3);
    rd16(3'd4, c); check("R7 capture into reload reg", c, 16'h0777);
    rd16(3'd2, c); check("R7 count unchanged by capture", c, 16'h0777);
    check("R7 external flag", {15'h0, irqExt}, 16'h1);
    trigPin = 1'b1; stepN(4);
    wrReg(3'd0, 8'h04); setReload(16'h1111); setCount(16'hFFFF); wrReg(3'd1, 8'h03);
    wrReg(3'd0, 8'h05);
    stepN(1); rd16(3'd2, c);
    check("R7 capture mode wraps to zero", c, 16'h0000);
    check("R7 capture mode overflow flag", {15'h0, irqMain}, 16'h1);
    idle();
  endtask

  task automatic tEdges();
    logic [15:0] c;
    idle(); wrReg(3'd0, 8'h04); wrReg(3'd1, 8'h30); setCount(16'h0100);
    trigPin = 1'b0; stepN(4); rd16(3'd4, c); check("R8 rising mode ignores fall", c, 16'h1111);
    trigPin = 1'b1; stepN(4); rd16(3'd4, c); check("R8 rising mode captures", c, 16'h0100);
    wrReg(3'd1, 8'h10); setCount(16'h0200);
    trigPin = 1'b0; stepN(4); rd16(3'd4, c); check("R8 any-edge fall", c, 16'h0200);
    setCount(16'h0300);
    trigPin = 1'b1; stepN(4); rd16(3'd4, c); check("R8 any-edge rise", c, 16'h0300);
    wrReg(3'd1, 8'h20); setCount(16'h0400);
    trigPin = 1'b0; stepN(4); rd16(3'd4, c); check("R8 code 10 falling", c, 16'h0400);
    setCount(16'h0500);
    trigPin = 1'b1; stepN(4); rd16(3'd4, c); check("R8 code 10 ignores rise", c, 16'h0400);
    idle();
  endtask

  task automatic tCapture1();
    logic [15:0] c;
    idle(); wrReg(3'd1, 8'h08); wrReg(3'd0, 8'h04); setCount(16'h0333);
    cntPinIn = 1'b0; stepN(3);
    rd16(3'd6, c); check("R9 capture-1 value", c, 16'h0333);
    check("R9 capture-1 flag", {15'h0, irqMain}, 16'h1);
    rd16(3'd4, c); check("R9 reload reg untouched", c, 16'h0400);
    cntPinIn = 1'b1; stepN(4);
    wrReg(3'd0, 8'h04); setCount(16'hFFFF); wrReg(3'd1, 8'h0B);
    wrReg(3'd0, 8'h05);
    stepN(1); rd16(3'd2, c);
    check("R9 wrap with capture-1 on", c, 16'h0000);
    check("R9 overflow leaves flag clear", {15'h0, irqMain}, 16'h0);
    idle();
  endtask

  task automatic tClkOut();
    idle(); setReload(16'hFFFE); setCount(16'hFFFE); wrReg(3'd1, 8'h07);
    check("R10 pin driven", {15'h0, cntPinOe}, 16'h1);
    check("R10 initial level", {15'h0, cntPinOut}, 16'h0);
    wrReg(3'd0, 8'h01);
    stepN(1); check("R10 before wrap", {15'h0, cntPinOut}, 16'h0);
    stepN(1); check("R10 toggle on wrap", {15'h0, cntPinOut}, 16'h1);
    stepN(2); check("R10 second toggle", {15'h0, cntPinOut}, 16'h0);
    idle();
  endtask

  task automatic tExtCount();
    logic [15:0] c;
    idle(); setCount(16'h0000); wrReg(3'd1, 8'h03); wrReg(3'd0, 8'h03);
    stepN(10); rd16(3'd2, c); check("R11 no prescaler ticks", c, 16'h0000);
    cntPinIn = 1'b0; stepN(3); rd16(3'd2, c); check("R11 fall counts", c, 16'h0001);
    cntPinIn = 1'b1; stepN(4); rd16(3'd2, c); check("R11 rise ignored", c, 16'h0001);
    cntPinIn = 1'b0; stepN(3); rd16(3'd2, c); check("R11 second fall", c, 16'h0002);
    cntPinIn = 1'b1; stepN(4);
    idle();
  endtask

  task automatic tSameCycle();
    logic [15:0] c;
    idle(); setCount(16'h0010); wrReg(3'd0, 8'h07);
    trigPin = 1'b0; cntPinIn = 1'b0; stepN(3);
    rd16(3'd2, c); check("R12 count advanced", c, 16'h0011);
    rd16(3'd4, c); check("R12 capture holds pre-increment", c, 16'h0010);
    trigPin = 1'b1; cntPinIn = 1'b1; stepN(4);
    idle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    stepN(1);
    tReset();
    tRates();
    tReloadOvf();
    tBaud();
    tExtReload();
    tCapture2();
    tEdges();
    tCapture1();
    tClkOut();
    tExtCount();
    tSameCycle();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule